// File: doc/BRIEF.md
# Banked Modem Control Register File

This block is the small processor-facing register bank of a modem data pump. A host reaches it over a plain synchronous bus: an address, write data and a write enable that take effect on the rising clock edge, plus read data that follows the address combinationally. Two ordinary 8-bit registers are held: a mode register and a line register. The line register's address is shared with an auxiliary register that is normally out of view.

Bit 6 of the mode register is the bank switch. While it is one, every access at the line address reaches the auxiliary register instead, and the line register keeps its contents. Clearing the bit brings the line register back at that address.

The auxiliary register mixes two kinds of bits. Some are read-only status sampled from the datapath: the transmit baud clock and the received bit ahead of the descrambler. The others are stored control bits: the transmit data source select and a 2-bit signal-quality threshold code. The stored control bits drive the transmit-source and signal-quality logic directly.

Top module: `modem_regbank`

## Requirements
- R1: After reset the mode, line and auxiliary stored bits are all zero. Reads at addresses 2 and 3 return 0x00 while both live inputs are low, `txSrcAlt` is 0 and `sqThresh` is 2'b00.
- R2: The mode register at address 2 and, while mode bit 6 is zero, the line register at address 3 store a full byte on a write and return it on a read.
- R3: While mode bit 6 is one, a read or write at address 3 reaches the auxiliary register, and the line register is left unchanged.
- R4: Writing mode bit 6 back to zero restores line register access at address 3 with its earlier contents, and the auxiliary stored bits are kept.
- R5: Auxiliary read bits 7, 4 and 0 are always zero, whatever was written.
- R6: Auxiliary read bit 6 shows `txBaudClk` and bit 5 shows `rxRawBit`, each delayed by SYNC_STAGES clock edges (default 2).
- R7: Writes to auxiliary bits 7 to 4 have no effect on what is read back.
- R8: Auxiliary bit 3 is stored and drives `txSrcAlt` (0 = transmit pin, 1 = alternate source). Auxiliary bits 2:1 are stored and drive `sqThresh`, where code 00 is the default threshold.
- R9: Read data reflects register contents before any write in the same cycle. A cycle that writes the mode register reads the old value.
- R10: Addresses other than 2 and 3 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe, takes effect at the clock edge |
| busRdData | output | 8 | Combinational read data for busAddr |
| txBaudClk | input | 1 | Live transmit baud clock from the datapath |
| rxRawBit | input | 1 | Received bit before descrambling |
| modeCtrl | output | 8 | Mode register contents |
| lineCtrl | output | 8 | Line register contents |
| txSrcAlt | output | 1 | Transmit data source select |
| sqThresh | output | 2 | Signal-quality threshold code |

## Verification
A wrong bank selection shows up at once. The next read at address 3 returns the wrong register, or a write at that address disturbs `lineCtrl` or `txSrcAlt`/`sqThresh` on the following edge. A stored bit at an unused or read-only position becomes visible on the first mapped read. A broken status path shows as bit 6 or 5 not following its live input after the synchronizer delay. A write committed a cycle early would be caught by reading the mode register during the writing cycle itself.

// File: rtl/modem_regbank_pkg.sv
package modem_regbank_pkg;

  localparam int DATA_W  = 8;
  localparam int MAP_BIT = 6;

  // one-hot write strobes from decode to storage
  typedef struct packed {
    logic wrMode;
    logic wrLine;
    logic wrAux;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MODE = 2'd1,
    RD_LINE = 2'd2,
    RD_AUX  = 2'd3
  } rdSel_t;

  typedef struct packed {
    wrStrobe_t wr;
    rdSel_t    rd;
  } ctrlStrobe_t;

endpackage

// File: rtl/modem_regbank_ctrl.sv
module modem_regbank_ctrl
  import modem_regbank_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int MODE_ADDR = 2,
  parameter int LINE_ADDR = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              mapActive,
  output ctrlStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] LINE_A = ADDR_W'(LINE_ADDR);

  logic hitMode;
  logic hitLine;

  assign hitMode = (busAddr == MODE_A);
  assign hitLine = (busAddr == LINE_A);

  always_comb begin
    strobe.wr.wrMode = busWrEn && hitMode;
    strobe.wr.wrLine = busWrEn && hitLine && !mapActive;
    strobe.wr.wrAux  = busWrEn && hitLine && mapActive;
    if (hitMode)                    strobe.rd = RD_MODE;
    else if (hitLine && mapActive)  strobe.rd = RD_AUX;
    else if (hitLine)               strobe.rd = RD_LINE;
    else                            strobe.rd = RD_NONE;
  end

endmodule

// File: rtl/modem_regbank_dp.sv
module modem_regbank_dp
  import modem_regbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              txBaudClk,
  input  logic              rxRawBit,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] modeCtrl,
  output logic [DATA_W-1:0] lineCtrl,
  output logic              mapActive,
  output logic              txSrcAlt,
  output logic [1:0]        sqThresh
);

  logic [DATA_W-1:0] modeReg;
  logic [DATA_W-1:0] lineReg;
  logic [3:1]        auxCfg;   // bit3 source select, bits2:1 threshold
  logic [1:0]        liveBits; // {baud clock, raw rx bit}
  logic [DATA_W-1:0] auxView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      lineReg <= '0;
      auxCfg  <= '0;
    end else begin
      if (strobe.wr.wrMode) modeReg <= busWrData;
      if (strobe.wr.wrLine) lineReg <= busWrData;
      if (strobe.wr.wrAux)  auxCfg  <= busWrData[3:1];
    end
  end

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign liveBits = {txBaudClk, rxRawBit};
    end else begin : g_sync
      logic [1:0] stageQ [SYNC_STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < SYNC_STAGES; i++) stageQ[i] <= '0;
        end else begin
          stageQ[0] <= {txBaudClk, rxRawBit};
          for (int i = 1; i < SYNC_STAGES; i++) stageQ[i] <= stageQ[i-1];
        end
      end
      assign liveBits = stageQ[SYNC_STAGES-1];
    end
  endgenerate

  assign auxView = {1'b0, liveBits[1], liveBits[0], 1'b0, auxCfg, 1'b0};

  always_comb begin
    unique case (strobe.rd)
      RD_MODE: busRdData = modeReg;
      RD_LINE: busRdData = lineReg;
      RD_AUX:  busRdData = auxView;
      default: busRdData = '0;
    endcase
  end

  assign modeCtrl  = modeReg;
  assign lineCtrl  = lineReg;
  assign mapActive = modeReg[MAP_BIT];
  assign txSrcAlt  = auxCfg[3];
  assign sqThresh  = auxCfg[2:1];

endmodule

// File: rtl/modem_regbank.sv
module modem_regbank
  import modem_regbank_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int MODE_ADDR   = 2,
  parameter int LINE_ADDR   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              txBaudClk,
  input  logic              rxRawBit,
  output logic [DATA_W-1:0] modeCtrl,
  output logic [DATA_W-1:0] lineCtrl,
  output logic              txSrcAlt,
  output logic [1:0]        sqThresh
);

  ctrlStrobe_t strobe;
  logic        mapActive;

  modem_regbank_ctrl #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .LINE_ADDR(LINE_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .mapActive(mapActive), .strobe(strobe)
  );

  modem_regbank_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .txBaudClk(txBaudClk), .rxRawBit(rxRawBit), .busRdData(busRdData),
    .modeCtrl(modeCtrl), .lineCtrl(lineCtrl), .mapActive(mapActive),
    .txSrcAlt(txSrcAlt), .sqThresh(sqThresh)
  );

endmodule

// File: rtl/modem_regbank_chk.sv
module modem_regbank_chk #(
  parameter int ADDR_W    = 3,
  parameter int MODE_ADDR = 2,
  parameter int LINE_ADDR = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWrData,
  input logic              busWrEn,
  input logic [7:0]        busRdData,
  input logic [7:0]        modeCtrl,
  input logic [7:0]        lineCtrl,
  input logic              txSrcAlt,
  input logic [1:0]        sqThresh
);

  logic atMode, atLine, mapped;
  assign atMode = (busAddr == ADDR_W'(MODE_ADDR));
  assign atLine = (busAddr == ADDR_W'(LINE_ADDR));
  assign mapped = modeCtrl[6];

  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && atMode) |=> (modeCtrl == $past(busWrData)));

  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && atLine && mapped) |=> $stable(lineCtrl));

  p_aux_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && atLine && !mapped) |=> ($stable(txSrcAlt) && $stable(sqThresh)));

  p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (atLine && mapped) |-> (busRdData[7] == 1'b0 && busRdData[4] == 1'b0 && busRdData[0] == 1'b0));

  p_aux_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && atLine && mapped) |=>
      (txSrcAlt == $past(busWrData[3]) && sqThresh == $past(busWrData[2:1])));

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!atLine && !atMode) |-> (busRdData == 8'h00));

endmodule

bind modem_regbank modem_regbank_chk #(
  .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .LINE_ADDR(LINE_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWrEn(busWrEn), .busRdData(busRdData), .modeCtrl(modeCtrl),
  .lineCtrl(lineCtrl), .txSrcAlt(txSrcAlt), .sqThresh(sqThresh)
);

// File: tb/modem_regbank_bench.sv
`timescale 1ns/1ps
module modem_regbank_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busRdData;
  logic       txBaudClk = 1'b0;
  logic       rxRawBit = 1'b0;
  logic [7:0] modeCtrl, lineCtrl;
  logic       txSrcAlt;
  logic [1:0] sqThresh;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  modem_regbank u_modem_regbank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .txBaudClk(txBaudClk),
    .rxRawBit(rxRawBit), .modeCtrl(modeCtrl), .lineCtrl(lineCtrl),
    .txSrcAlt(txSrcAlt), .sqThresh(sqThresh)
  );

  // {write?, addr, data, expected read at addr afterwards, requirement no.}
  typedef struct packed {
    logic       we;
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd2, 8'h15, 8'h15, 4'd2},  // R2 mode byte
    '{1'b1, 3'd3, 8'hA7, 8'hA7, 4'd2},  // R2 line byte
    '{1'b1, 3'd2, 8'h55, 8'h55, 4'd3},  // R3 set bank bit
    '{1'b0, 3'd3, 8'h00, 8'h00, 4'd3},  // R3 aux seen, not line
    '{1'b1, 3'd3, 8'hFF, 8'h0E, 4'd5},  // R5 R7 unused/read-only masked
    '{1'b1, 3'd3, 8'h04, 8'h04, 4'd8},  // R8 threshold code 10
    '{1'b1, 3'd2, 8'h15, 8'h15, 4'd4},  // R4 clear bank bit
    '{1'b0, 3'd3, 8'h00, 8'hA7, 4'd4},  // R4 line restored (R3 line kept)
    '{1'b1, 3'd2, 8'h40, 8'h40, 4'd4},  // R4 remap
    '{1'b0, 3'd3, 8'h00, 8'h04, 4'd4},  // R4 aux kept
    '{1'b1, 3'd5, 8'hFF, 8'h00, 4'd10}  // R10 unmapped address
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(3'd2, rd); check("R1 mode", rd, 8'h00);
    busRead(3'd3, rd); check("R1 line", rd, 8'h00);
    check("R1 outputs", {5'd0, txSrcAlt, sqThresh}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].we) busWrite(VECS[i].addr, VECS[i].data);
      busRead(VECS[i].addr, rd);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
    end
    // R3 line register untouched by mapped writes
    check("R3 lineCtrl", lineCtrl, 8'hA7);
    // R10 unmapped write changed nothing
    busRead(3'd0, rd); check("R10 addr0", rd, 8'h00);

    // R8 outputs follow stored aux bits (mapped now)
    busWrite(3'd3, 8'h08);
    check("R8 src alt", {6'd0, txSrcAlt, sqThresh[0]}, 8'h02);
    check("R8 thr zero", {6'd0, sqThresh}, 8'h00);
    busWrite(3'd3, 8'h06);
    check("R8 thr 11", {5'd0, txSrcAlt, sqThresh}, 8'h03);

    // R6 live status with synchronizer delay
    @(negedge clk); txBaudClk = 1'b1; rxRawBit = 1'b1;
    repeat (3) @(negedge clk);
    busRead(3'd3, rd); check("R6 both high", rd, 8'h66);
    @(negedge clk); txBaudClk = 1'b0;
    repeat (3) @(negedge clk);
    busRead(3'd3, rd); check("R6 raw only", rd, 8'h26);

    // R7 read-only bits unaffected by write
    busWrite(3'd3, 8'hF0);
    busRead(3'd3, rd); check("R7 ro ignored", rd, 8'h20);

    // R9 read during a mode write sees old value
    @(negedge clk);
    busAddr = 3'd2; busWrData = 8'h00; busWrEn = 1'b1;
    #1 check("R9 old value", busRdData, 8'h40);
    @(negedge clk); busWrEn = 1'b0;
    #1 check("R9 new value", busRdData, 8'h00);

    // R1 mid-run reset clears everything
    busWrite(3'd3, 8'h3C);
    @(negedge clk); rxRawBit = 1'b0; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRead(3'd3, rd); check("R1 line after reset", rd, 8'h00);
    check("R1 mode after reset", modeCtrl, 8'h00);

    finish_run();
  end

endmodule